// File: doc/BRIEF.md
# Serial Two-Wire Register Access Port

This block is a target on a two-wire serial bus (I2C-compatible). It gives the bus controller read and write access to a bank of 8-bit configuration registers that sits inside the block. A fast system clock samples the bus clock and data lines. The block pulls the data line low through an open-drain enable and otherwise releases it. One strap input picks which of two device addresses the block answers to.

A write transaction carries three kinds of byte in turn: the device address with the direction bit clear, a register subaddress, and then any number of data bytes. Each data byte lands in the register the pointer selects, and the pointer then moves up by one.

A read sets the pointer with a short write, then sends a repeated start and the device address with the direction bit set. The block then streams register contents, moving the pointer up after every byte the controller acknowledges, until the controller answers with a no-acknowledge.

The edges of the register map have fixed behaviour. The block refuses a subaddress outside the map. Reads that run off the top keep returning the top register. Writes that run off the top are dropped and refused.

Top module: `i2cRegPort`

## Requirements
- R1: The block acknowledges an address byte only if its upper seven bits equal 0x20 with bit 0 replaced by the strap input. Bit 0 of the address byte is the direction flag, 1 for read and 0 for write. With the strap low, the accepted bytes are 0x40 (write) and 0x41 (read). With the strap high, they are 0x42 and 0x43. The block leaves every other address byte unanswered.
- R2: The acknowledge is the data line held low for the whole ninth clock pulse. The block changes its drive on the data line only while the bus clock is low.
- R3: In a write, the first byte after the address is stored as the register pointer. Every later data byte is stored in the register the pointer selects and acknowledged, and the pointer then increments.
- R4: A subaddress of 0xF9 or above is not acknowledged. The block returns to idle, so data bytes that follow in the same transaction are not acknowledged and change no register.
- R5: A read that follows a repeated start begins at the pointer left by the preceding write. Each byte the controller acknowledges advances the pointer by one.
- R6: Once a read has moved the pointer past subaddress 0xF8, every further byte sent carries the contents of register 0xF8.
- R7: A data byte written while the pointer is past 0xF8 is stored nowhere and is not acknowledged, and the block returns to idle.
- R8: A no-acknowledge from the controller after a read byte ends the read. The block releases the data line and drives nothing more until the next start.
- R9: A stop condition (data rising while the clock is high) at any bit position returns the block to idle. A byte cut short by the stop is not written.
- R10: After reset the data line is released and every register reads 0x00.
- R11: A start condition (data falling while the clock is high) at any bit position discards the partial byte and begins a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level (wired value on the bus) |
| addrSel | input | 1 | Strap; selects bit 0 of the 7-bit device address |
| sdaDriveLow | output | 1 | Open-drain enable: 1 pulls the data line low, 0 releases it |

## Verification
The bench sweeps every 7-bit address with both strap levels. A wrong comparison shows up there as an answer to a foreign address, or as silence on the block's own address. It fills all 249 registers in one burst, then reads them all back in one burst through a repeated start, so a pointer that skips, wraps or fails to persist returns the wrong byte. It then pushes both directions past the top register. A block that wrapped there would either return register 0 or overwrite the top register with the refused byte. Every out-of-map subaddress is tried, and stops and starts are inserted mid-byte. A design that committed partial bytes, or did not resynchronise on those conditions, would corrupt a register or fail to acknowledge the retried address.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } ctrlState_t;

  // Strobes from the bus controller into the datapath.
  typedef struct packed {
    logic sampleBit;   // shift bus data into the receive register
    logic latchPtr;    // load pointer from the received byte
    logic commitWrite; // store the received byte at the pointer
    logic advancePtr;  // step the pointer (saturating one past the top)
    logic loadTx;      // fetch transmit byte from the (new) pointer
    logic shiftTx;     // move to the next transmit bit
  } dpStrobe_t;

endpackage

// File: rtl/i2cSyncEdge.sv
module i2cSyncEdge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe;
  logic prev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe <= '1;
      prev <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], lineIn};
      prev <= pipe[STAGES-1];
    end
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~prev;
  assign fall = ~pipe[STAGES-1] & prev;
endmodule

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cRegPkg::*;
#(
  parameter int NUM_REGS = 249,
  parameter int PTR_W    = $clog2(NUM_REGS + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  dp,
  input  logic       sdaLvl,
  output logic [7:0] rxByte,
  output logic       subValid,
  output logic       ptrInRange,
  output logic       txBit
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(NUM_REGS);
  localparam logic [PTR_W-1:0] TOP   = PTR_W'(NUM_REGS - 1);

  logic [7:0]       rxShift;
  logic [7:0]       txShift;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptrNext;
  logic [PTR_W-1:0] loadSrc;
  logic [PTR_W-1:0] rdIdx;
  logic [7:0]       regFile [NUM_REGS];

  assign rxByte     = rxShift;
  assign subValid   = {24'd0, rxShift} < 32'(NUM_REGS);
  assign ptrInRange = ptr < LIMIT;
  assign txBit      = txShift[7];

  assign ptrNext = (ptr < LIMIT) ? ptr + PTR_W'(1) : ptr;
  assign loadSrc = dp.advancePtr ? ptrNext : ptr;
  assign rdIdx   = (loadSrc > TOP) ? TOP : loadSrc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (dp.sampleBit) begin
      rxShift <= {rxShift[6:0], sdaLvl};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (dp.latchPtr) begin
      ptr <= PTR_W'(rxShift);
    end else if (dp.advancePtr) begin
      ptr <= ptrNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (dp.loadTx) begin
      txShift <= regFile[rdIdx];
    end else if (dp.shiftTx) begin
      txShift <= {txShift[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= '0;
    end else if (dp.commitWrite && ptrInRange) begin
      regFile[ptr] <= rxShift;
    end
  end

  // R6: the pointer never runs more than one step past the top register.
  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LIMIT);

  // R4: a latched subaddress is always inside the map.
  p_latch_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    dp.latchPtr |=> (ptr < LIMIT));

  // R7: a store is only requested for an in-map pointer.
  p_commit_in_map_r7: assert property (@(posedge clk) disable iff (!rstN)
    dp.commitWrite |-> (ptr < LIMIT));

  // R3: a store moves the pointer up by exactly one.
  p_store_steps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dp.commitWrite && dp.advancePtr) |=> (ptr == $past(ptr) + PTR_W'(1)));
endmodule

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLvl,
  input  logic       sdaRise,
  input  logic       sdaFall,
  input  logic [6:0] devAddr,
  input  logic [7:0] rxByte,
  input  logic       subValid,
  input  logic       ptrInRange,
  input  logic       txBit,
  output dpStrobe_t  dp,
  output logic       sdaDriveLow
);
  ctrlState_t state, stNext;
  logic [3:0] bitCnt, cntNext;
  logic       readMode, rdNext;
  logic       masterAck, mAckNext;
  logic       startSeen, stopSeen, byteDone;

  assign startSeen = sclLvl & sdaFall;
  assign stopSeen  = sclLvl & sdaRise;
  assign byteDone  = (bitCnt == 4'd8);

  always_comb begin
    stNext   = state;
    cntNext  = bitCnt;
    rdNext   = readMode;
    mAckNext = masterAck;
    dp       = '0;
    if (stopSeen) begin
      stNext  = ST_IDLE;
      cntNext = '0;
    end else if (startSeen) begin
      stNext  = ST_ADDR;
      cntNext = '0;
    end else begin
      case (state)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (sclRise && !byteDone) begin
            dp.sampleBit = 1'b1;
            cntNext      = bitCnt + 4'd1;
          end else if (sclFall && byteDone) begin
            cntNext = '0;
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == devAddr) begin
                stNext = ST_ADDR_ACK;
                rdNext = rxByte[0];
              end else begin
                stNext = ST_IDLE;
              end
            end else if (state == ST_SUB) begin
              if (subValid) begin
                dp.latchPtr = 1'b1;
                stNext      = ST_SUB_ACK;
              end else begin
                stNext = ST_IDLE;
              end
            end else begin
              if (ptrInRange) begin
                dp.commitWrite = 1'b1;
                dp.advancePtr  = 1'b1;
                stNext         = ST_WR_ACK;
              end else begin
                stNext = ST_IDLE;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            cntNext = '0;
            if (readMode) begin
              dp.loadTx = 1'b1;
              stNext    = ST_RD;
            end else begin
              stNext = ST_SUB;
            end
          end
        end
        ST_SUB_ACK, ST_WR_ACK: begin
          if (sclFall) begin
            cntNext = '0;
            stNext  = ST_WR;
          end
        end
        ST_RD: begin
          if (sclRise && !byteDone) begin
            cntNext = bitCnt + 4'd1;
          end else if (sclFall && bitCnt != 4'd0) begin
            if (byteDone) begin
              cntNext = '0;
              stNext  = ST_RD_ACK;
            end else begin
              dp.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            mAckNext = ~sdaLvl;
          end else if (sclFall) begin
            if (masterAck) begin
              dp.advancePtr = 1'b1;
              dp.loadTx     = 1'b1;
              stNext        = ST_RD;
            end else begin
              stNext = ST_IDLE;
            end
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      readMode  <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stNext;
      bitCnt    <= cntNext;
      readMode  <= rdNext;
      masterAck <= mAckNext;
    end
  end

  assign sdaDriveLow = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) ||
                       (state == ST_WR_ACK) || ((state == ST_RD) && !txBit);

  // R8: nothing is driven while idle.
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaDriveLow);

  // R2: the drive on the data line only moves while the bus clock is low.
  p_drive_moves_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclLvl);

  // R1: the address acknowledge only follows a byte that matches the device.
  p_ack_on_match_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR_ACK) |-> (rxByte[7:1] == devAddr));

  // R9: a stop always lands in idle.
  p_stop_to_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> (state == ST_IDLE));

  // R11: a start always restarts address reception from bit zero.
  p_start_restarts_r11: assert property (@(posedge clk) disable iff (!rstN)
    startSeen |=> (state == ST_ADDR && bitCnt == 4'd0));

  // R3: the bit counter never exceeds one byte.
  p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);
endmodule

// File: rtl/i2cRegPort.sv
module i2cRegPort #(
  parameter int         NUM_REGS      = 249,
  parameter logic [6:0] DEV_ADDR_BASE = 7'h20,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrSel,
  output logic sdaDriveLow
);
  import i2cRegPkg::*;

  localparam int LINES = 2; // index 1 = clock line, index 0 = data line

  logic [LINES-1:0] rawLine, lineLvl, lineRise, lineFall;
  logic [6:0]       devAddr;
  dpStrobe_t        dp;
  logic [7:0]       rxByte;
  logic             subValid, ptrInRange, txBit;

  assign rawLine = {sclIn, sdaIn};
  assign devAddr = {DEV_ADDR_BASE[6:1], addrSel};

  for (genvar l = 0; l < LINES; l++) begin : g_sync
    i2cSyncEdge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rstN  (rstN),
      .lineIn(rawLine[l]),
      .lvl   (lineLvl[l]),
      .rise  (lineRise[l]),
      .fall  (lineFall[l])
    );
  end

  i2cRegCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclLvl     (lineLvl[1]),
    .sclRise    (lineRise[1]),
    .sclFall    (lineFall[1]),
    .sdaLvl     (lineLvl[0]),
    .sdaRise    (lineRise[0]),
    .sdaFall    (lineFall[0]),
    .devAddr    (devAddr),
    .rxByte     (rxByte),
    .subValid   (subValid),
    .ptrInRange (ptrInRange),
    .txBit      (txBit),
    .dp         (dp),
    .sdaDriveLow(sdaDriveLow)
  );

  i2cRegDatapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dp        (dp),
    .sdaLvl    (lineLvl[0]),
    .rxByte    (rxByte),
    .subValid  (subValid),
    .ptrInRange(ptrInRange),
    .txBit     (txBit)
  );
endmodule

// File: tb/i2cRegPort_tb.sv
module i2cRegPort_tb;
  localparam int QTR = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic addrSel = 1'b0;
  logic sdaDriveLow;
  logic busSda;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  assign busSda = mSda & ~sdaDriveLow;

  i2cRegPort u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda),
    .addrSel(addrSel), .sdaDriveLow(sdaDriveLow)
  );

  function automatic logic [7:0] fVal(input int i);
    return 8'((i * 37 + 11) & 8'hFF);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; wq(); mScl = 1'b1; wq(); mSda = 1'b0; wq(); mScl = 1'b0; wq();
  endtask

  task automatic busStop();
    mSda = 1'b0; wq(); mScl = 1'b1; wq(); mSda = 1'b1; wq();
  endtask

  task automatic putBit(input logic b);
    mSda = b; wq(); mScl = 1'b1; wq(); wq(); mScl = 1'b0; wq();
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; wq(); mScl = 1'b1; wq(); b = busSda; wq(); mScl = 1'b0; wq();
  endtask

  task automatic putByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = ~b;
  endtask

  task automatic getByte(input logic ackIt, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      getBit(b);
      v[i] = b;
    end
    putBit(~ackIt);
  endtask

  // Single-register read through a write of the pointer and a repeated start.
  task automatic readOne(input logic [7:0] devW, input logic [7:0] sub,
                         input logic [7:0] expv, input string req);
    logic ak;
    logic [7:0] v;
    busStart(); putByte(devW, ak); putByte(sub, ak);
    busStart(); putByte(devW | 8'h01, ak);
    chk(req, "read address ack", int'(ak), 1);
    getByte(1'b0, v);
    busStop();
    chk(req, $sformatf("reg %0h", sub), int'(v), int'(expv));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ak;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    chk("R10", "drive in reset", int'(sdaDriveLow), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10", "drive after reset", int'(sdaDriveLow), 0);

    // R10: registers start at zero.
    busStart(); putByte(8'h40, ak); putByte(8'h00, ak);
    busStart(); putByte(8'h41, ak);
    for (int k = 0; k < 4; k++) begin
      getByte(k < 3, v);
      chk("R10", "reset contents", int'(v), 0);
    end
    busStop();

    // R1: full address sweep with both strap levels.
    for (int s = 0; s < 2; s++) begin
      addrSel = s[0];
      wq();
      for (int a = 0; a < 128; a++) begin
        busStart(); putByte({a[6:0], 1'b0}, ak); busStop();
        chk("R1", $sformatf("addr %0h strap %0d", a, s), int'(ak),
            (a == (32'h20 | s)) ? 1 : 0);
      end
    end
    addrSel = 1'b0;
    wq();

    // R3, R2: burst fill of the whole map; R7: byte past the top refused.
    busStart(); putByte(8'h40, ak);
    chk("R2", "address ack", int'(ak), 1);
    putByte(8'h00, ak);
    chk("R3", "subaddress ack", int'(ak), 1);
    for (int i = 0; i < 249; i++) begin
      putByte(fVal(i), ak);
      chk("R3", $sformatf("data ack %0d", i), int'(ak), 1);
    end
    putByte(8'hEE, ak);
    chk("R7", "byte past top ack", int'(ak), 0);
    busStop();

    // R5: burst read-back; R6: reads past the top; R8: release after NACK.
    busStart(); putByte(8'h40, ak); putByte(8'h00, ak);
    busStart(); putByte(8'h41, ak);
    for (int i = 0; i < 249; i++) begin
      getByte(1'b1, v);
      chk("R5", $sformatf("burst reg %0d", i), int'(v), int'(fVal(i)));
    end
    for (int k = 0; k < 3; k++) begin
      getByte(k < 2, v);
      chk("R6", "top repeat (R7 top kept)", int'(v), int'(fVal(248)));
    end
    wq();
    chk("R8", "released after nack", int'(sdaDriveLow), 0);
    getBit(ak);
    chk("R8", "line idle after nack", int'(ak), 1);
    busStop();

    // R4: every out-of-map subaddress refused, following data refused too.
    for (int s = 249; s < 256; s++) begin
      busStart(); putByte(8'h40, ak);
      putByte(s[7:0], ak);
      chk("R4", $sformatf("sub %0h ack", s), int'(ak), 0);
      putByte(8'h5A, ak);
      chk("R4", "data after bad sub ack", int'(ak), 0);
      busStop();
    end
    readOne(8'h40, 8'h00, fVal(0), "R4");
    readOne(8'h40, 8'hF8, fVal(248), "R4");

    // R6: read started directly at the top register.
    busStart(); putByte(8'h40, ak); putByte(8'hF8, ak);
    busStart(); putByte(8'h41, ak);
    getByte(1'b1, v);
    chk("R6", "direct top first", int'(v), int'(fVal(248)));
    getByte(1'b0, v);
    chk("R6", "direct top second", int'(v), int'(fVal(248)));
    busStop();

    // R9: stop in the middle of a data byte.
    busStart(); putByte(8'h40, ak); putByte(8'h05, ak);
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b0);
    busStop();
    readOne(8'h40, 8'h05, fVal(5), "R9");

    // R11: start in the middle of a byte, then a complete transaction.
    busStart(); putByte(8'h40, ak); putByte(8'h06, ak);
    putBit(1'b1); putBit(1'b1); putBit(1'b0);
    busStart(); putByte(8'h40, ak);
    chk("R11", "address after mid-byte start", int'(ak), 1);
    putByte(8'h06, ak); putByte(8'h5A, ak);
    chk("R11", "data ack after restart", int'(ak), 1);
    busStop();
    readOne(8'h40, 8'h06, 8'h5A, "R11");

    // R5: pointer carried across the repeated start.
    busStart(); putByte(8'h40, ak); putByte(8'h0A, ak);
    putByte(8'h11, ak); putByte(8'h22, ak);
    busStart(); putByte(8'h41, ak);
    getByte(1'b1, v);
    chk("R5", "carry reg 0c", int'(v), int'(fVal(12)));
    getByte(1'b0, v);
    chk("R5", "carry reg 0d", int'(v), int'(fVal(13)));
    busStop();
    readOne(8'h40, 8'h0B, 8'h22, "R3");

    // R1: strap high moves the device to 0x42/0x43.
    addrSel = 1'b1;
    wq();
    busStart(); putByte(8'h42, ak); putByte(8'h14, ak); putByte(8'h99, ak);
    busStop();
    chk("R1", "strap high write ack", int'(ak), 1);
    readOne(8'h42, 8'h14, 8'h99, "R1");
    busStart(); putByte(8'h40, ak); busStop();
    chk("R1", "low address ignored with strap high", int'(ak), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule